// File: doc/BRIEF.md
# Timer Count Capture and Byte Readout

This block sits next to one down-counter of a three-counter timer. It watches the timer's shared control-register write port for a capture command aimed at its own counter. When such a command arrives and no earlier capture is still waiting to be read, it freezes the counter's live 16-bit value into a holding register.

Reads of the counter's data port return one byte at a time. The byte order follows the access mode that was programmed for the counter. While a captured value is waiting, reads return the frozen value. Otherwise they return the live count, with the same byte sequencing.

In two-byte mode both bytes must be read before the frozen value is released. Any other traffic may occur between the two reads. A reconfigure strobe for this counter drops a waiting capture and restarts the byte order at the low byte.

Top module: `cnt_latch_rd`

## Requirements
- R1: A control write whose bits 7:6 equal this counter's index (0, 1 or 2) and whose bits 5:4 are 00 is a capture command. When no capture is waiting, it stores the live count and marks a capture as waiting from the next cycle on.
- R2: A control write with bits 7:6 equal to 11 is never a capture command, whatever bits 5:0 hold.
- R3: A control write that names another counter in bits 7:6, or that has nonzero bits 5:4, has no effect on this counter.
- R4: A capture command that arrives while a capture is waiting is ignored; the first stored value is kept.
- R5: `acc_mode` encodes the access mode: 01 is low byte only, 10 is high byte only, 11 is low byte then high byte, and 00 behaves as low byte only. `rd_data` shows the selected byte combinationally, in the same cycle as `rd_stb`.
- R6: In mode 11 the byte pointer toggles on each `rd_stb`. A waiting capture is released only by the read of the high byte, which also returns the pointer to the low byte.
- R7: In modes 00, 01 and 10, a single `rd_stb` releases a waiting capture.
- R8: When no capture is waiting, `rd_data` is taken from the live count `count_i`.
- R9: `reconf` clears a waiting capture and sets the pointer to the low byte from the next cycle on. It takes priority over a capture command and a read in the same cycle.
- R10: After reset no capture is waiting and the pointer is at the low byte.
- R11: Control writes between the two byte reads of mode 11 do not move the byte pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 16 | Live value of the down-counter |
| cw_we | input | 1 | Control-register write strobe |
| cw_data | input | 8 | Control-register write byte |
| rd_stb | input | 1 | Read strobe of this counter's data port |
| reconf | input | 1 | Reconfigure strobe for this counter |
| acc_mode | input | 2 | Programmed access mode (01 low, 10 high, 11 low then high) |
| rd_data | output | 8 | Byte returned by the data port |

## Verification
The live count falls by three on every cycle, so any read tells a frozen value apart from a live one.

Capture commands are sent in several forms:
- the correct code for this counter;
- the code for another counter;
- the read-back code;
- a code with nonzero bits 5:4;
- a repeat while a capture is still waiting.

Each form shows whether the decode and the first-capture-wins rule hold. Byte reads run in every access mode. In two-byte mode, control writes are placed between the two reads, which exposes a pointer that moves or a capture that is released early. Reconfigure strobes fall in the middle of a sequence to show that the capture is cleared and the pointer restarts.

// File: rtl/cl_pkg.sv
package cl_pkg;

  typedef enum logic [1:0] {
    ACC_LOW_ALT = 2'b00,
    ACC_LOW     = 2'b01,
    ACC_HIGH    = 2'b10,
    ACC_BOTH    = 2'b11
  } acc_mode_e;

  localparam logic [1:0] SEL_READBACK = 2'b11;
  localparam logic [1:0] CMD_CAPTURE  = 2'b00;

endpackage

// File: rtl/cl_cmd_decode.sv
module cl_cmd_decode #(
  parameter int BYTE_W  = 8,
  parameter int CTR_IDX = 0
) (
  input  logic              cw_we,
  input  logic [BYTE_W-1:0] cw_data,
  output logic              latch_cmd
);
  import cl_pkg::*;

  localparam logic [1:0] MY_SEL = CTR_IDX[1:0];

  logic [1:0] sel_f;
  logic [1:0] cmd_f;

  always_comb begin
    sel_f     = cw_data[BYTE_W-1 -: 2];
    cmd_f     = cw_data[BYTE_W-3 -: 2];
    latch_cmd = cw_we
              && (sel_f == MY_SEL)
              && (sel_f != SEL_READBACK)
              && (cmd_f == CMD_CAPTURE);
  end

endmodule

// File: rtl/cl_byte_seq.sv
module cl_byte_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_stb,
  input  logic       reconf,
  input  logic [1:0] acc_mode,
  output logic       ptr_q,
  output logic       hi_sel,
  output logic       rd_done
);
  import cl_pkg::*;

  logic ptr_d;
  logic ptr_en;
  logic two_byte;

  always_comb begin
    two_byte = (acc_mode == ACC_BOTH);
    hi_sel   = (acc_mode == ACC_HIGH) || (two_byte && ptr_q);
    rd_done  = rd_stb && (!two_byte || ptr_q);
    ptr_en   = reconf || (rd_stb && two_byte);
    ptr_d    = reconf ? 1'b0 : ~ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= 1'b0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

endmodule

// File: rtl/cl_hold_reg.sv
module cl_hold_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch_cmd,
  input  logic             rd_done,
  input  logic             reconf,
  input  logic [CNT_W-1:0] count_i,
  output logic             pend_q,
  output logic [CNT_W-1:0] hold_q
);

  logic pend_d;
  logic cap_en;

  always_comb begin
    cap_en = latch_cmd && !pend_q && !reconf;
    pend_d = pend_q;
    if (reconf) begin
      pend_d = 1'b0;
    end else begin
      if (rd_done) pend_d = 1'b0;
      if (cap_en)  pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (cap_en) begin
      hold_q <= count_i;
    end
  end

endmodule

// File: rtl/cnt_latch_rd.sv
module cnt_latch_rd #(
  parameter int BYTE_W  = 8,
  parameter int CTR_IDX = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*BYTE_W-1:0] count_i,
  input  logic                cw_we,
  input  logic [BYTE_W-1:0]   cw_data,
  input  logic                rd_stb,
  input  logic                reconf,
  input  logic [1:0]          acc_mode,
  output logic [BYTE_W-1:0]   rd_data
);

  localparam int CNT_W = 2 * BYTE_W;

  logic             latch_cmd;
  logic             ptr_q;
  logic             hi_sel;
  logic             rd_done;
  logic             pend_q;
  logic [CNT_W-1:0] hold_q;
  logic [CNT_W-1:0] src_val;

  cl_cmd_decode #(.BYTE_W(BYTE_W), .CTR_IDX(CTR_IDX)) u_dec (
    .cw_we     (cw_we),
    .cw_data   (cw_data),
    .latch_cmd (latch_cmd)
  );

  cl_byte_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_stb   (rd_stb),
    .reconf   (reconf),
    .acc_mode (acc_mode),
    .ptr_q    (ptr_q),
    .hi_sel   (hi_sel),
    .rd_done  (rd_done)
  );

  cl_hold_reg #(.CNT_W(CNT_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .latch_cmd (latch_cmd),
    .rd_done   (rd_done),
    .reconf    (reconf),
    .count_i   (count_i),
    .pend_q    (pend_q),
    .hold_q    (hold_q)
  );

  always_comb begin
    src_val = pend_q ? hold_q : count_i;
    rd_data = hi_sel ? src_val[CNT_W-1 -: BYTE_W] : src_val[BYTE_W-1:0];
  end

endmodule

// File: rtl/cl_chk.sv
module cl_chk #(
  parameter int BYTE_W  = 8,
  parameter int CTR_IDX = 0
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2*BYTE_W-1:0] count_i,
  input logic                cw_we,
  input logic [BYTE_W-1:0]   cw_data,
  input logic                rd_stb,
  input logic                reconf,
  input logic [1:0]          acc_mode,
  input logic [BYTE_W-1:0]   rd_data,
  input logic                pend_q,
  input logic [2*BYTE_W-1:0] hold_q,
  input logic                ptr_q
);

  localparam logic [1:0] MY_SEL = CTR_IDX[1:0];

  logic good_cmd;
  logic rdbk_cmd;

  always_comb begin
    good_cmd = cw_we && (cw_data[BYTE_W-1 -: 2] == MY_SEL)
            && (MY_SEL != 2'b11) && (cw_data[BYTE_W-3 -: 2] == 2'b00);
    rdbk_cmd = cw_we && (cw_data[BYTE_W-1 -: 2] == 2'b11);
  end

  AST_CAPTURE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    good_cmd && !pend_q && !reconf |=> pend_q && (hold_q == $past(count_i))); // R1

  AST_READBACK_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rdbk_cmd && !pend_q |=> !pend_q); // R2

  AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !reconf && !rd_stb |=> pend_q && $stable(hold_q)); // R4

  AST_LOW_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && (acc_mode == 2'b01) |-> rd_data == hold_q[BYTE_W-1:0]); // R5

  AST_BOTH_FIRST_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !ptr_q && rd_stb && (acc_mode == 2'b11) && !reconf |=> pend_q && ptr_q); // R6

  AST_LIVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q && (acc_mode == 2'b10) |-> rd_data == count_i[2*BYTE_W-1 -: BYTE_W]); // R8

  AST_RECONF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    reconf |=> !pend_q && !ptr_q); // R9

endmodule

bind cnt_latch_rd cl_chk #(.BYTE_W(BYTE_W), .CTR_IDX(CTR_IDX)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .count_i  (count_i),
  .cw_we    (cw_we),
  .cw_data  (cw_data),
  .rd_stb   (rd_stb),
  .reconf   (reconf),
  .acc_mode (acc_mode),
  .rd_data  (rd_data),
  .pend_q   (pend_q),
  .hold_q   (hold_q),
  .ptr_q    (ptr_q)
);

// File: tb/cnt_latch_rd_tb.sv
module cnt_latch_rd_tb;

  localparam int IDX = 1;

  logic        clk;
  logic        rst_n;
  logic [15:0] count_i;
  logic        cw_we;
  logic [7:0]  cw_data;
  logic        rd_stb;
  logic        reconf;
  logic [1:0]  acc_mode;
  logic [7:0]  rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bit          m_pend;
  bit          m_ptr;
  logic [15:0] m_hold;
  logic [15:0] live;

  cnt_latch_rd #(.BYTE_W(8), .CTR_IDX(IDX)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_i  (count_i),
    .cw_we    (cw_we),
    .cw_data  (cw_data),
    .rd_stb   (rd_stb),
    .reconf   (reconf),
    .acc_mode (acc_mode),
    .rd_data  (rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic step(input logic we, input logic [7:0] d, input logic rd,
                      input logic rc, input logic [1:0] md, input string tag);
    logic [15:0] src;
    logic [7:0]  exp;
    bit          hi;
    bit          lat;
    bit          fin;
    bit          np;

    @(negedge clk);
    cw_we    = we;
    cw_data  = d;
    rd_stb   = rd;
    reconf   = rc;
    acc_mode = md;
    count_i  = live;
    #2;

    src = m_pend ? m_hold : live;
    hi  = (md == 2'b10) || (md == 2'b11 && m_ptr);
    exp = hi ? src[15:8] : src[7:0];
    total++;
    if (rd_data !== exp) begin
      bad++;
      $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, exp);
    end

    @(posedge clk);
    lat = we && (d[7:6] == IDX[1:0]) && (d[7:6] != 2'b11) && (d[5:4] == 2'b00);
    if (rc) begin
      m_pend = 1'b0;
      m_ptr  = 1'b0;
    end else begin
      fin = rd && (md != 2'b11 || m_ptr);
      np  = m_pend;
      if (fin) np = 1'b0;
      if (lat && !m_pend) begin
        np     = 1'b1;
        m_hold = live;
      end
      if (rd && md == 2'b11) m_ptr = !m_ptr;
      m_pend = np;
    end
    live = live - 16'd3;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    cw_we    = 1'b0;
    cw_data  = 8'h00;
    rd_stb   = 1'b0;
    reconf   = 1'b0;
    acc_mode = 2'b11;
    live     = 16'hA5C3;
    count_i  = live;
    m_pend   = 1'b0;
    m_ptr    = 1'b0;
    m_hold   = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: after reset, the output shows the live low byte
    step(0, 8'h00, 0, 0, 2'b11, "R10");
    // R8: live reads with byte sequencing
    step(0, 8'h00, 1, 0, 2'b11, "R8");
    step(0, 8'h00, 1, 0, 2'b11, "R8");
    // R1: capture, then idle while the count moves on
    step(1, 8'h40, 0, 0, 2'b11, "R1");
    step(0, 8'h00, 0, 0, 2'b11, "R1");
    step(0, 8'h00, 1, 0, 2'b11, "R6");
    // R11 and R4: control writes between the two byte reads
    step(1, 8'h40, 0, 0, 2'b11, "R11");
    step(1, 8'h36, 0, 0, 2'b11, "R11");
    step(0, 8'h00, 1, 0, 2'b11, "R6");
    step(0, 8'h00, 1, 0, 2'b11, "R6");
    step(0, 8'h00, 1, 0, 2'b11, "R6");
    // R4: a second capture command is ignored
    step(1, 8'h40, 0, 0, 2'b11, "R4");
    step(0, 8'h00, 0, 0, 2'b11, "R4");
    step(1, 8'h40, 0, 0, 2'b11, "R4");
    step(0, 8'h00, 1, 0, 2'b11, "R4");
    step(0, 8'h00, 1, 0, 2'b11, "R4");
    // R2: the read-back code never captures
    step(1, 8'hC0, 0, 0, 2'b11, "R2");
    step(1, 8'hFE, 0, 0, 2'b11, "R2");
    step(0, 8'h00, 1, 0, 2'b11, "R2");
    step(0, 8'h00, 1, 0, 2'b11, "R2");
    // R3: another counter, or nonzero bits 5:4
    step(1, 8'h00, 0, 0, 2'b11, "R3");
    step(1, 8'h80, 0, 0, 2'b11, "R3");
    step(1, 8'h70, 0, 0, 2'b11, "R3");
    step(1, 8'h50, 0, 0, 2'b11, "R3");
    step(0, 8'h00, 1, 0, 2'b11, "R3");
    step(0, 8'h00, 1, 0, 2'b11, "R3");
    // R9: reconfigure in the middle of a sequence
    step(1, 8'h40, 0, 0, 2'b11, "R9");
    step(0, 8'h00, 1, 0, 2'b11, "R9");
    step(0, 8'h00, 0, 1, 2'b11, "R9");
    step(0, 8'h00, 1, 0, 2'b11, "R9");
    step(0, 8'h00, 1, 0, 2'b11, "R9");
    // R9: reconfigure wins over a capture in the same cycle
    step(1, 8'h40, 0, 1, 2'b11, "R9");
    step(0, 8'h00, 1, 0, 2'b11, "R9");
    step(0, 8'h00, 1, 0, 2'b11, "R9");
    // R7 and R5: low-byte-only mode
    step(0, 8'h00, 0, 1, 2'b01, "R5");
    step(1, 8'h40, 0, 0, 2'b01, "R5");
    step(0, 8'h00, 0, 0, 2'b01, "R5");
    step(0, 8'h00, 1, 0, 2'b01, "R7");
    step(0, 8'h00, 1, 0, 2'b01, "R7");
    // R7 and R5: high-byte-only mode
    step(0, 8'h00, 0, 1, 2'b10, "R5");
    step(1, 8'h40, 0, 0, 2'b10, "R5");
    step(0, 8'h00, 1, 0, 2'b10, "R7");
    step(0, 8'h00, 1, 0, 2'b10, "R7");
    // R5: mode 00 behaves as low byte only
    step(0, 8'h00, 0, 1, 2'b00, "R5");
    step(1, 8'h40, 0, 0, 2'b00, "R5");
    step(0, 8'h00, 1, 0, 2'b00, "R7");
    step(0, 8'h00, 1, 0, 2'b00, "R8");
    // R1: a capture and a live read in the same cycle
    step(1, 8'h40, 1, 0, 2'b00, "R1");
    step(0, 8'h00, 0, 0, 2'b00, "R1");
    step(0, 8'h00, 1, 0, 2'b00, "R7");
    // R4: a capture in the cycle that releases the first one is ignored
    step(0, 8'h00, 0, 1, 2'b11, "R9");
    step(1, 8'h40, 0, 0, 2'b11, "R4");
    step(0, 8'h00, 1, 0, 2'b11, "R4");
    step(1, 8'h40, 1, 0, 2'b11, "R4");
    step(0, 8'h00, 1, 0, 2'b11, "R4");
    step(0, 8'h00, 1, 0, 2'b11, "R4");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule